// File: doc/BRIEF.md
# Feed-forward equaliser tap data switch matrix

This block sits between a wide parallel data path and a quarter-rate segmented transmit driver. Each core clock it accepts one parallel word, 16 bits by default, whose bit 0 goes onto the line first. It spreads the bits over four quarter-rate phase lanes, at 0, 90, 180 and 270 degrees. For every phase it builds four tap lanes: a pre-cursor, the main cursor, a first post-cursor and a second post-cursor. A four-tap feed-forward equaliser can then pick each driver segment's data from the tap it is assigned to.

Every tap lane is a group of four bits in the order a later 4:1 serializer shifts them out. Read in serial order, the main-cursor lanes carry the input stream one bit late. The pre-cursor lanes run one bit ahead of the main cursor. The two post-cursor lanes run one and two bits behind it. The taps that reach back across a word boundary need bits from the previous word. So the block keeps the top three bits of the last accepted word in a small history register. Every output is registered, and an output valid flag follows the input valid.

Top module: `ffe_tap_switch_matrix`

## Requirements
- R1: While rst_n is low, out_valid is 0, out_data is all zeros and the history register is cleared. As a result, history-sourced bits of the first word accepted after reset read as 0.
- R2: out_valid equals the in_valid of the previous clock cycle.
- R3: The flat index of a bit in out_data is i = (k*4 + t)*4 + s. Here k is the phase (0 to 3 for 0, 90, 180 and 270 degrees) and s is the serializer slot (0 is shifted out first). The tap code t is 0 for pre-cursor, 1 for main cursor, 2 for first post-cursor and 3 for second post-cursor. When n = 4*s + k - t is 0 or more, bit i is bit n of the word accepted in the previous cycle.
- R4: When n = 4*s + k - t is negative, bit i is bit n+16 (13, 14 or 15) of the word accepted before the one in R3. If no such word has been accepted since reset, bit i is 0.
- R5: The history register loads only on a cycle with in_valid high. Idle cycles between two words do not change which previous word R4 refers to.
- R6: With the default HOLD_ON_IDLE = 1, out_data keeps its last value on the cycle after an idle input cycle. With HOLD_ON_IDLE = 0 it reads zero instead.
- R7: Take the lanes in serial order, position p = 4*s + k of each word. The main-cursor lanes then reproduce the input bit stream delayed by one bit. The pre-cursor lane at any position equals the main-cursor lane one position later, and the two post-cursor lanes are the main stream delayed by one and two bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Parallel word present this cycle |
| in_data | input | 16 | Parallel word, bit 0 first on the line |
| out_valid | output | 1 | Registered copy of in_valid |
| out_data | output | 64 | Phase × tap × slot lanes, index (k*4+t)*4+s |

## Verification
Every result is due one clock after the word that produces it. That covers out_valid, the in-word lane bits and the held data after an idle cycle. History-sourced bits are due in the same cycle, but they come from the most recent earlier valid word, however many idle cycles lie between the two. The bench drives inputs on the falling edge. It samples outputs on the next falling edge, before it drives again, so each sample sees exactly one rising edge of effect. Its model keeps the whole serial bit stream as a queue. It derives each lane as that stream offset by the tap delay, with positions before the first bit reading as zero.

// File: rtl/ffe_sw_pkg.sv
package ffe_sw_pkg;

   // Tap codes; the tap code also equals its delay in serial bits
   // relative to the pre-cursor lane.
   typedef enum logic [1:0] {
      TAP_PRE   = 2'd0,
      TAP_MAIN  = 2'd1,
      TAP_POST1 = 2'd2,
      TAP_POST2 = 2'd3
   } tap_code_e;

   // Serial position inside a word of a lane bit, before the tap delay.
   function automatic int lane_pos(input int phase, input int slot, input int phases);
      return slot * phases + phase;
   endfunction

   // Source bit of the current word for (phase, tap, slot); negative
   // values point into the history of the previous word.
   function automatic int src_bit(input int phase, input int tap, input int slot,
                                  input int phases);
      return lane_pos(phase, slot, phases) - tap;
   endfunction

   // Flat position of a lane bit inside the output bundle.
   function automatic int flat_idx(input int phase, input int tap, input int slot,
                                   input int taps, input int slots);
      return (phase * taps + tap) * slots + slot;
   endfunction

endpackage

// File: rtl/ffe_sw_history.sv
module ffe_sw_history #(
   parameter int WORD_W = 16,
   parameter int HIST_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] word_i,
   output logic [HIST_W-1:0] hist_o
);

   localparam int TOP_LSB = WORD_W - HIST_W;

   generate
      if (HIST_W < 1 || HIST_W >= WORD_W) begin : g_bad_hist
         $error("ffe_sw_history: HIST_W must be in 1..WORD_W-1");
      end
   endgenerate

   logic [HIST_W-1:0] hist_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
      end else if (load) begin
         hist_q <= word_i[WORD_W-1:TOP_LSB];
      end
   end

   assign hist_o = hist_q;

   logic unused_low;
   assign unused_low = ^word_i[TOP_LSB-1:0];

   // R5: idle cycles leave the history untouched
   a_r5_hist_stable : assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(hist_o));

   // R5: a valid word deposits its top bits
   a_r5_hist_load : assert property (@(posedge clk) disable iff (!rst_n)
      load |=> hist_o == $past(word_i[WORD_W-1:TOP_LSB]));

endmodule

// File: rtl/ffe_sw_phase_router.sv
module ffe_sw_phase_router
   import ffe_sw_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int PHASES = 4,
   parameter int TAPS   = 4,
   parameter int PHASE  = 0,
   localparam int SLOTS  = WORD_W / PHASES,
   localparam int HIST_W = TAPS - 1,
   localparam int LANE_W = TAPS * SLOTS
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic [HIST_W-1:0] hist_i,
   output logic [LANE_W-1:0] lanes_o
);

   generate
      if (PHASE < 0 || PHASE >= PHASES) begin : g_bad_phase
         $error("ffe_sw_phase_router: PHASE out of range");
      end
   endgenerate

   // Each lane bit is a pure wire: either a bit of the current word or,
   // for positions reaching before bit 0, a held bit of the previous word.
   for (genvar t = 0; t < TAPS; t++) begin : g_tap
      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
         localparam int N = src_bit(PHASE, t, s, PHASES);
         if (N >= 0) begin : g_cur
            assign lanes_o[t*SLOTS + s] = word_i[N];
         end else begin : g_hist
            assign lanes_o[t*SLOTS + s] = hist_i[N + HIST_W];
         end
      end
   end

   logic unused_in;
   assign unused_in = ^{word_i, hist_i};

endmodule

// File: rtl/ffe_sw_out_reg.sv
module ffe_sw_out_reg #(
   parameter int OUT_W        = 64,
   parameter bit HOLD_ON_IDLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid_i,
   input  logic [OUT_W-1:0] data_i,
   output logic             valid_o,
   output logic [OUT_W-1:0] data_o
);

   logic             valid_q;
   logic [OUT_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= 1'b0;
      else        valid_q <= valid_i;
   end

   generate
      if (HOLD_ON_IDLE) begin : g_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       data_q <= '0;
            else if (valid_i) data_q <= data_i;
         end

         // R6: idle input leaves the bundle as it was
         a_r6_hold_idle : assert property (@(posedge clk) disable iff (!rst_n)
            !valid_i |=> $stable(data_o));
      end else begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       data_q <= '0;
            else if (valid_i) data_q <= data_i;
            else              data_q <= '0;
         end

         // R6: idle input clears the bundle in this variant
         a_r6_clear_idle : assert property (@(posedge clk) disable iff (!rst_n)
            !valid_i |=> data_o == '0);
      end
   endgenerate

   assign valid_o = valid_q;
   assign data_o  = data_q;

endmodule

// File: rtl/ffe_tap_switch_matrix.sv
module ffe_tap_switch_matrix
   import ffe_sw_pkg::*;
#(
   parameter int WORD_W       = 16,
   parameter int PHASES       = 4,
   parameter int TAPS         = 4,
   parameter bit HOLD_ON_IDLE = 1'b1,
   localparam int SLOTS  = WORD_W / PHASES,
   localparam int HIST_W = TAPS - 1,
   localparam int LANE_W = TAPS * SLOTS,
   localparam int OUT_W  = PHASES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_data,
   output logic              out_valid,
   output logic [OUT_W-1:0]  out_data
);

   generate
      if (PHASES < 1 || (WORD_W % PHASES) != 0) begin : g_bad_split
         $error("ffe_tap_switch_matrix: WORD_W must be a multiple of PHASES");
      end
      if (TAPS < 2 || TAPS > WORD_W) begin : g_bad_taps
         $error("ffe_tap_switch_matrix: TAPS must be in 2..WORD_W");
      end
   endgenerate

   logic [HIST_W-1:0] hist;
   logic [OUT_W-1:0]  bundle;

   ffe_sw_history #(
      .WORD_W (WORD_W),
      .HIST_W (HIST_W)
   ) u_hist (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (in_valid),
      .word_i (in_data),
      .hist_o (hist)
   );

   for (genvar k = 0; k < PHASES; k++) begin : g_phase
      ffe_sw_phase_router #(
         .WORD_W (WORD_W),
         .PHASES (PHASES),
         .TAPS   (TAPS),
         .PHASE  (k)
      ) u_route (
         .word_i  (in_data),
         .hist_i  (hist),
         .lanes_o (bundle[k*LANE_W +: LANE_W])
      );
   end

   ffe_sw_out_reg #(
      .OUT_W        (OUT_W),
      .HOLD_ON_IDLE (HOLD_ON_IDLE)
   ) u_oreg (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_i (in_valid),
      .data_i  (bundle),
      .valid_o (out_valid),
      .data_o  (out_data)
   );

   localparam int IDX_MAIN_P0S1 = flat_idx(0, int'(TAP_MAIN), 1, TAPS, SLOTS);
   localparam int SRC_MAIN_P0S1 = src_bit(0, int'(TAP_MAIN), 1, PHASES);
   localparam int IDX_PRE_P0S0  = flat_idx(0, int'(TAP_PRE), 0, TAPS, SLOTS);
   localparam int IDX_MAIN_P1S0 = flat_idx(1, int'(TAP_MAIN), 0, TAPS, SLOTS);

   // R2: valid out is the one-cycle-late valid in
   a_r2_valid_follow : assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> out_valid == $past(in_valid));

   // R3: an in-word main-cursor bit lands one cycle later
   if (SLOTS > 1) begin : g_a_r3
      a_r3_main_lane : assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_data[IDX_MAIN_P0S1] == $past(in_data[SRC_MAIN_P0S1]));
   end

   // R7: pre-cursor at one position equals main cursor one position later
   if (PHASES > 1) begin : g_a_r7
      a_r7_tap_align : assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> out_data[IDX_PRE_P0S0] == out_data[IDX_MAIN_P1S0]);
   end

endmodule

// File: tb/tb_ffe_tap_switch_matrix.sv
module tb_ffe_tap_switch_matrix;

   localparam int W = 16;
   localparam int P = 4;
   localparam int T = 4;
   localparam int S = W / P;
   localparam int OW = P * T * S;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [W-1:0]  in_data = '0;
   logic          out_valid;
   logic [OW-1:0] out_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   ffe_tap_switch_matrix dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   // Reference: the whole serial bit stream, one entry per line bit.
   bit            stream[$];
   int            word_cnt = 0;
   logic          exp_valid = 1'b0;
   logic [OW-1:0] exp_data = '0;
   logic [OW-1:0] mask_cur;
   logic [OW-1:0] mask_wrap;
   int            cur_base = 0;

   task automatic check(input string req, input logic [OW-1:0] act,
                        input logic [OW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit ref_bit(input int idx);
      return (idx >= 0) ? stream[idx] : 1'b0;
   endfunction

   // Lane (k,t,s) of word w: stream position 16w + 4s + k, delayed t bits.
   function automatic logic [OW-1:0] build(input int w);
      logic [OW-1:0] v = '0;
      for (int k = 0; k < P; k++)
         for (int t = 0; t < T; t++)
            for (int s = 0; s < S; s++)
               v[(k*T + t)*S + s] = ref_bit(W*w + s*P + k - t);
      return v;
   endfunction

   task automatic compare();
      check("R2 valid", {{(OW-1){1'b0}}, out_valid}, {{(OW-1){1'b0}}, exp_valid});
      if (exp_valid) begin
         check("R3 in-word lanes", out_data & mask_cur, exp_data & mask_cur);
         check("R4 history lanes", out_data & mask_wrap, exp_data & mask_wrap);
         begin
            logic [OW-1:0] a = '0;
            logic [OW-1:0] e = '0;
            for (int p = 0; p < W; p++) begin
               a[p] = out_data[((p % P)*T + 1)*S + p / P];
               e[p] = ref_bit(cur_base + p - 1);
            end
            check("R7 main stream one bit late", a, e);
         end
      end else begin
         check("R6 hold on idle", out_data, exp_data);
      end
   endtask

   task automatic step(input logic v, input logic [W-1:0] d);
      @(negedge clk);
      compare();
      if (v) begin
         for (int i = 0; i < W; i++) stream.push_back(d[i]);
         exp_data = build(word_cnt);
         cur_base = W * word_cnt;
         word_cnt++;
      end
      exp_valid = v;
      in_valid  = v;
      in_data   = d;
   endtask

   initial begin
      mask_cur  = '0;
      mask_wrap = '0;
      for (int k = 0; k < P; k++)
         for (int t = 0; t < T; t++)
            for (int s = 0; s < S; s++)
               if (s*P + k - t >= 0) mask_cur[(k*T + t)*S + s] = 1'b1;
               else                  mask_wrap[(k*T + t)*S + s] = 1'b1;
   end

   initial begin
      logic [W-1:0] lfsr = 16'hACE1;
      repeat (3) @(negedge clk);
      check("R1 reset valid", {{(OW-1){1'b0}}, out_valid}, '0);
      check("R1 reset data", out_data, '0);
      rst_n = 1'b1;
      // First word after reset: history bits must read as zero (R1, R4).
      step(1'b1, 16'hFFFF);
      step(1'b1, 16'h0000);
      step(1'b1, 16'hFFFF);
      step(1'b1, 16'hA5C3);
      // Idle gap: output holds, history keeps word 0xA5C3 (R5, R6).
      step(1'b0, 16'h1234);
      step(1'b0, 16'hFFFF);
      step(1'b1, 16'h0001);
      for (int i = 0; i < W; i++) step(1'b1, 16'h0001 << i);
      step(1'b1, 16'h8000);
      step(1'b0, 16'h0000);
      step(1'b1, 16'h1FFF);
      step(1'b1, 16'hE000);
      for (int i = 0; i < 120; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step((i % 7) != 3, lfsr);
      end
      step(1'b0, 16'h0000);
      step(1'b0, 16'h0000);
      @(negedge clk);
      compare();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #20000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule